// File: doc/BRIEF.md
# Multi-lane parallel-to-serial transmitter

This block turns one parallel word per lane per frame into a serial bit stream on each of up to sixteen lanes. Everything runs on one fast bit clock. A one-cycle frame strobe, asserted once every FACTOR bit clocks, stands in for the slow frame-rate clock. It also marks the cycle in which a new word is taken from the parallel bus. The serialization factor is fixed at elaboration to 4, 7 or 8. A factor of 1 skips the shifter and passes the word bit straight to the lane.

By default an input register captures the parallel bus on each strobe. The shifter then loads that captured word on the following strobe, so each word leaves one frame after it was presented. Along with the lanes the block produces two more outputs. The first is a forwarded frame clock, which is high for the first half of each frame and rises with the first bit of the word. The second is a lock flag, which goes high once a set number of frame strobes have been seen after reset.

Top module: `mls_serializer`

## Requirements
- R1: After reset, and until the first frame strobe, every lane output, the frame clock output and the lock flag are all 0.
- R2: Lane n (numbered from 0) carries the word held in par_in bits [FACTOR*n+FACTOR-1 : FACTOR*n], where the higher index is the more significant bit.
- R3: With the input register on, the word on par_in in a strobe cycle appears on its lane starting in the cycle after the next strobe. The first frame after reset carries all zeros.
- R4: Within a frame the bits leave most significant bit first, one per bit clock, FACTOR bits per frame. At a strobe the shifter loads the new word instead of shifting.
- R5: The frame clock goes high in the bit slot that carries a word's most significant bit. It stays high for ceil(FACTOR/2) slots, which is 4 for FACTOR 8, and is low for the remaining slots of the frame. It rises only after a strobe.
- R6: The lock flag stays 0 until LOCK_FRAMES strobes have been counted since reset. It goes to 1 after the strobe that completes the count and then stays at 1.
- R7: Changes on par_in in cycles without a strobe have no effect on any lane output.
- R8: Asserting rst_n low at any time clears the lane outputs, the frame clock and the lock flag at once. The captured word is also cleared, so the first frame after reset is again all zeros.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_en | input | 1 | Frame strobe, one cycle high every FACTOR clocks |
| par_in | input | LANES*FACTOR | Parallel words, one FACTOR-bit slice per lane |
| ser_out | output | LANES | One serial bit per lane |
| frame_clk_out | output | 1 | Forwarded frame-rate clock aligned with the lane data |
| locked | output | 1 | High once LOCK_FRAMES strobes have been counted |

## Verification
Two things happen together at every frame boundary. The shifter loads a new word in the same cycle it would otherwise shift out the last bit of the old word, and the input register captures the next word in that same cycle. The bench drives back-to-back frames whose words differ in their end bits, for example 0x01 followed by 0x80 and 0xAA followed by 0x55. A reference deserializer then rebuilds every lane word from the sampled bits and compares it with the word presented one frame earlier. Any shift across the boundary, or a load taken from the wrong register, shows up as a wrong bit at the start or end of a word.

// File: rtl/mls_pkg.sv
`timescale 1ns/1ps
package mls_pkg;

  // bits needed to index the bit slots of one frame
  function automatic int unsigned slot_w(int unsigned f);
    return (f < 2) ? 1 : $clog2(f);
  endfunction

  // number of bit slots per frame for which the frame clock is high
  function automatic int unsigned high_slots(int unsigned f);
    return (f + 1) / 2;
  endfunction

endpackage

// File: rtl/mls_rst_sync.sv
`timescale 1ns/1ps
module mls_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/mls_frame_ctl.sv
`timescale 1ns/1ps
module mls_frame_ctl
  import mls_pkg::*;
#(
  parameter int unsigned FACTOR      = 8,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_en,
  output logic frame_clk_o,
  output logic locked_o
);

  localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_FRAMES - 1);

  // lock counter: counts strobes until the target is reached
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (frame_en && !lock_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;

  generate
    if (FACTOR > 1) begin : g_slots
      localparam int unsigned PW   = slot_w(FACTOR);
      localparam int unsigned HALF = high_slots(FACTOR);
      localparam logic [PW-1:0] LAST = PW'(FACTOR - 1);
      localparam logic [PW-1:0] MID  = PW'(HALF - 1);

      logic [PW-1:0] ph_q, ph_d;
      logic          fclk_q, fclk_d;

      always_comb begin
        ph_d   = ph_q;
        fclk_d = fclk_q;
        if (frame_en) begin
          ph_d   = '0;
          fclk_d = 1'b1;
        end else begin
          if (ph_q != LAST) ph_d = ph_q + 1'b1;
          if (ph_q == MID)  fclk_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ph_q   <= LAST;
          fclk_q <= 1'b0;
        end else begin
          ph_q   <= ph_d;
          fclk_q <= fclk_d;
        end
      end

      assign frame_clk_o = fclk_q;
    end else begin : g_pass
      // factor 1: every cycle is a frame, the clock follows the strobe
      logic fclk_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fclk_q <= 1'b0;
        else        fclk_q <= frame_en;
      end
      assign frame_clk_o = fclk_q;
    end
  endgenerate

endmodule

// File: rtl/mls_lane.sv
`timescale 1ns/1ps
module mls_lane #(
  parameter int unsigned FACTOR = 8,
  parameter bit          IN_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [FACTOR-1:0] word_in,
  output logic              ser_o
);

  logic [FACTOR-1:0] staged;

  generate
    if (IN_REG) begin : g_inreg
      logic [FACTOR-1:0] hold_q, hold_d;

      always_comb hold_d = load_en ? word_in : hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
      end

      assign staged = hold_q;
    end else begin : g_direct
      assign staged = word_in;
    end

    if (FACTOR > 1) begin : g_shift
      logic [FACTOR-1:0] sh_q, sh_d;

      // a strobe loads the staged word, every other cycle shifts toward the MSB
      always_comb begin
        if (load_en) sh_d = staged;
        else         sh_d = {sh_q[FACTOR-2:0], 1'b0};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end

      assign ser_o = sh_q[FACTOR-1];
    end else begin : g_bypass
      assign ser_o = staged[0];
    end
  endgenerate

endmodule

// File: rtl/mls_serializer.sv
`timescale 1ns/1ps
module mls_serializer #(
  parameter int unsigned LANES       = 16,
  parameter int unsigned FACTOR      = 8,
  parameter bit          IN_REG      = 1'b1,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_en,
  input  logic [LANES*FACTOR-1:0]   par_in,
  output logic [LANES-1:0]          ser_out,
  output logic                      frame_clk_out,
  output logic                      locked
);

  logic rst_ns;

  mls_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  mls_frame_ctl #(
    .FACTOR      (FACTOR),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_ns),
    .frame_en    (frame_en),
    .frame_clk_o (frame_clk_out),
    .locked_o    (locked)
  );

  generate
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      mls_lane #(
        .FACTOR (FACTOR),
        .IN_REG (IN_REG)
      ) u_lane (
        .clk     (clk),
        .rst_n   (rst_ns),
        .load_en (frame_en),
        .word_in (par_in[n*FACTOR +: FACTOR]),
        .ser_o   (ser_out[n])
      );
    end
  endgenerate

endmodule

// File: rtl/mls_serializer_chk.sv
`timescale 1ns/1ps
module mls_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_en,
  input logic frame_clk_out,
  input logic locked
);

  // R5
  strobe_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |=> frame_clk_out);

  // R5
  fclk_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_clk_out) |-> $past(frame_en));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R6
  lock_rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_en));

endmodule

bind mls_serializer mls_serializer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_ns),
  .frame_en      (frame_en),
  .frame_clk_out (frame_clk_out),
  .locked        (locked)
);

// File: tb/tb_mls_serializer.sv
`timescale 1ns/1ps
module tb_mls_serializer;

  localparam int LANES = 16;
  localparam int F     = 8;
  localparam int LOCK  = 4;
  localparam int W     = LANES * F;
  localparam int HALF  = (F + 1) / 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           frame_en;
  logic [W-1:0]   par_in;
  logic [LANES-1:0] ser_out;
  logic           frame_clk_out;
  logic           locked;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_hold;
  int strobes;

  always #5 clk = ~clk;

  mls_serializer #(
    .LANES(LANES), .FACTOR(F), .IN_REG(1'b1), .LOCK_FRAMES(LOCK)
  ) dut (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .par_in(par_in),
    .ser_out(ser_out), .frame_clk_out(frame_clk_out), .locked(locked)
  );

  task automatic check(bit ok, string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(int seed);
    logic [W-1:0] w;
    for (int n = 0; n < LANES; n++) w[n*F +: F] = F'(seed*37 + n*11 + 5);
    return w;
  endfunction

  function automatic logic [W-1:0] rep(logic [F-1:0] b);
    return {LANES{b}};
  endfunction

  // drives one frame and rebuilds each lane word from the serial bits
  task automatic run_frame(logic [W-1:0] word, bit junk);
    logic [W-1:0] rx;
    logic [F-1:0] fpat;
    logic [F-1:0] fexp;
    logic lock_seen;
    rx = '0;
    fpat = '0;
    lock_seen = 1'b0;
    for (int s = 0; s < F; s++) begin
      frame_en = (s == 0);
      par_in   = (s == 0 || !junk) ? word : ~word;
      @(posedge clk);
      @(negedge clk);
      for (int n = 0; n < LANES; n++) rx[n*F + (F-1-s)] = ser_out[n];
      fpat[F-1-s] = frame_clk_out;
      if (s == 0) begin
        strobes++;
        lock_seen = locked;
      end
    end
    frame_en = 1'b0;
    for (int s = 0; s < F; s++) fexp[F-1-s] = (s < HALF);
    check(rx == exp_hold, "R2 R3 R4", "lane words", rx, exp_hold);
    check(fpat == fexp, "R5", "frame clock slots", W'(fpat), W'(fexp));
    check(lock_seen == (strobes >= LOCK), "R6", "lock flag", W'(lock_seen), W'(strobes >= LOCK));
    exp_hold = word;
  endtask

  task automatic release_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_hold = '0;
    strobes  = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    frame_en = 1'b0;
    par_in = mk(99);
    release_reset();
    // R1: quiet outputs while no strobe has arrived
    check(ser_out == '0, "R1", "lanes after reset", W'(ser_out), '0);
    check(frame_clk_out == 1'b0, "R1", "frame clock after reset", W'(frame_clk_out), '0);
    check(locked == 1'b0, "R1", "lock after reset", W'(locked), '0);
    repeat (5) @(negedge clk);
    check(ser_out == '0 && !frame_clk_out, "R1", "idle without strobe", W'(ser_out), '0);
  endtask

  task automatic t_lanes();
    for (int k = 1; k <= 6; k++) run_frame(mk(k), 1'b0);
  endtask

  task automatic t_back_to_back();
    // load at the boundary must replace the last shift
    run_frame(rep(8'h01), 1'b0);
    run_frame(rep(8'h80), 1'b0);
    run_frame(rep(8'hAA), 1'b0);
    run_frame(rep(8'h55), 1'b0);
    run_frame(rep(8'hFF), 1'b0);
    run_frame(rep(8'h00), 1'b0);
    run_frame(rep(8'h81), 1'b0);
  endtask

  task automatic t_ignore();
    // R7: inverted data between strobes must not reach the lanes
    run_frame(mk(40), 1'b1);
    run_frame(mk(41), 1'b1);
    run_frame(mk(42), 1'b0);
  endtask

  task automatic t_async_reset();
    frame_en = 1'b1;
    par_in = mk(50);
    @(posedge clk);
    #2 frame_en = 1'b0;
    @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    // R8: immediate clear
    check(ser_out == '0, "R8", "lanes in reset", W'(ser_out), '0);
    check(frame_clk_out == 1'b0 && locked == 1'b0, "R8", "clock and lock in reset",
          W'({frame_clk_out, locked}), '0);
    release_reset();
    for (int k = 0; k < LOCK + 1; k++) run_frame(mk(60 + k), 1'b0);
    run_frame(mk(70), 1'b0);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_lanes();
    t_back_to_back();
    t_ignore();
    t_async_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule